// File: doc/BRIEF.md
# Chip-Select Matcher with Online Spare Redirect

This block decides which memory rank answers a normalized DRAM controller address. It holds no configuration of its own. Each of its chip-select slots is described at the inputs by a base address, a don't-care mask and an enable bit. For each lookup, every enabled slot compares the address with its base on the bits that its mask does not cover. Among the slots that respond, the one with the lowest index is chosen.

The controller can retire one rank and send its accesses to an online spare rank. When the chosen slot is the retired one, the reported final rank becomes the spare. The spare's own base, mask and enable play no part in this. If the spare number does not name a slot that exists, the block flags an error instead of redirecting. Results are registered and appear one cycle after the lookup is presented.

Top module: `cs_matcher`

## Requirements
- R1: A slot whose enable bit is 0 never responds, even if its base and mask match the address.
- R2: An enabled slot responds when address and base agree on every bit where the slot's mask bit is 0. Mask bits that are 1 are don't-care.
- R3: When several slots respond, the lowest-numbered one is reported as the matched slot.
- R4: When no slot responds, the result has hit = 0, and matched slot, final slot, remapped and spare error are all 0.
- R5: When the matched slot equals the retired slot number and the spare number is below NUM_CS, the final slot is the spare number and remapped = 1. This holds whatever the spare slot's enable, base and mask are.
- R6: The final slot equals the matched slot and remapped = 0 when either condition applies: the matched slot differs from the retired number, or both the retired and spare numbers hold the unused marker 4'hF.
- R7: When redirect applies but the spare number is NUM_CS or higher (including 4'hF), the result has spare_err = 1, remapped = 0, and the final slot equal to the matched slot.
- R8: A lookup sampled with lookup_valid = 1 on a rising edge yields res_valid = 1 with its result just after that edge. A cycle with lookup_valid = 0 gives res_valid = 0 and leaves the other result outputs unchanged.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| lookup_valid | input | 1 | Presents a lookup this cycle |
| lookup_addr | input | ADDR_W | Normalized input address |
| cs_base_flat | input | NUM_CS*ADDR_W | Slot bases, slot i at bits [i*ADDR_W +: ADDR_W] |
| cs_mask_flat | input | NUM_CS*ADDR_W | Slot don't-care masks, same packing |
| cs_enable | input | NUM_CS | Per-slot enable, bit i for slot i |
| retired_cs | input | 4 | Number of the retired slot, 4'hF when unused |
| spare_cs | input | 4 | Number of the spare slot, 4'hF when unused |
| res_valid | output | 1 | Result registered this cycle |
| res_hit | output | 1 | Some slot responded |
| res_match_idx | output | 4 | Lowest responding slot |
| res_final_idx | output | 4 | Slot after spare redirect |
| res_remapped | output | 1 | Redirect to the spare was applied |
| res_spare_err | output | 1 | Redirect needed but spare number absent |

## Verification
On every result cycle, the assertions check several relations against their own copy of the sampled lookup. A reported hit must come from an enabled slot that matches under its mask, and no lower slot may also match. A miss must mean that no slot matches at all. A redirect must point at the sampled spare for the sampled retired slot, and remap and spare error never appear together. The one-cycle timing of res_valid is also checked. Two behaviours are left to the bench's directed and random scenarios because they depend on the chosen configuration. The first is that a spare disabled or mismatched in its own slot still receives the redirect. The second is that idle cycles hold the previous result, seen at the ports.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int CS_NUM_W = 4;

    typedef logic [CS_NUM_W-1:0] cs_num_t;

    // Marker for an unused retired/spare slot number
    localparam cs_num_t CS_NONE = '1;

    typedef struct packed {
        logic    valid;
        logic    hit;
        cs_num_t match_idx;
        cs_num_t final_idx;
        logic    remapped;
        logic    spare_err;
    } csm_result_t;
endpackage

// File: rtl/csm_bank_compare.sv
module csm_bank_compare #(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CS*ADDR_W-1:0] base_flat,
    input  logic [NUM_CS*ADDR_W-1:0] mask_flat,
    input  logic [NUM_CS-1:0]        enable,
    output logic [NUM_CS-1:0]        respond
);
    // One masked comparator per slot
    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        logic [ADDR_W-1:0] diff;
        always_comb begin
            diff       = (addr ^ base_flat[g*ADDR_W +: ADDR_W]) & ~mask_flat[g*ADDR_W +: ADDR_W];
            respond[g] = enable[g] && (diff == '0);
        end
    end
endmodule

// File: rtl/csm_first_hit.sv
module csm_first_hit
    import csm_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic [NUM_CS-1:0] req,
    output logic              found,
    output cs_num_t           idx
);
    // Scan from the top down so the lowest set bit is written last
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (req[i]) idx = cs_num_t'(i);
        end
    end
endmodule

// File: rtl/csm_spare_route.sv
module csm_spare_route
    import csm_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic    found,
    input  cs_num_t match_idx,
    input  cs_num_t retired_cs,
    input  cs_num_t spare_cs,
    output cs_num_t final_idx,
    output logic    remapped,
    output logic    spare_err
);
    localparam int CMP_W = CS_NUM_W + 1;

    logic both_unused;
    logic redirect;
    logic spare_present;

    always_comb begin
        both_unused   = (retired_cs == CS_NONE) && (spare_cs == CS_NONE);
        redirect      = found && !both_unused && (match_idx == retired_cs);
        spare_present = ({1'b0, spare_cs} < CMP_W'(NUM_CS));
        remapped      = redirect && spare_present;
        spare_err     = redirect && !spare_present;
        final_idx     = remapped ? spare_cs : match_idx;
    end
endmodule

// File: rtl/cs_matcher.sv
module cs_matcher
    import csm_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lookup_valid,
    input  logic [ADDR_W-1:0]        lookup_addr,
    input  logic [NUM_CS*ADDR_W-1:0] cs_base_flat,
    input  logic [NUM_CS*ADDR_W-1:0] cs_mask_flat,
    input  logic [NUM_CS-1:0]        cs_enable,
    input  logic [3:0]               retired_cs,
    input  logic [3:0]               spare_cs,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [3:0]               res_match_idx,
    output logic [3:0]               res_final_idx,
    output logic                     res_remapped,
    output logic                     res_spare_err
);
    // The marker value must not be a real slot number
    if (NUM_CS < 1 || NUM_CS > (1 << CS_NUM_W) - 1) begin : g_bad_num_cs
        initial $error("NUM_CS out of range");
    end

    logic [NUM_CS-1:0] respond;
    logic              found;
    cs_num_t           match_idx;
    cs_num_t           final_idx;
    logic              remapped;
    logic              spare_err;

    csm_result_t res_d, res_q;

    csm_bank_compare #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) i_compare (
        .addr      (lookup_addr),
        .base_flat (cs_base_flat),
        .mask_flat (cs_mask_flat),
        .enable    (cs_enable),
        .respond   (respond)
    );

    csm_first_hit #(.NUM_CS(NUM_CS)) i_first (
        .req   (respond),
        .found (found),
        .idx   (match_idx)
    );

    csm_spare_route #(.NUM_CS(NUM_CS)) i_route (
        .found      (found),
        .match_idx  (match_idx),
        .retired_cs (retired_cs),
        .spare_cs   (spare_cs),
        .final_idx  (final_idx),
        .remapped   (remapped),
        .spare_err  (spare_err)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (lookup_valid) begin
            res_d.valid     = 1'b1;
            res_d.hit       = found;
            res_d.match_idx = match_idx;
            res_d.final_idx = final_idx;
            res_d.remapped  = remapped;
            res_d.spare_err = spare_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid     = res_q.valid;
    assign res_hit       = res_q.hit;
    assign res_match_idx = res_q.match_idx;
    assign res_final_idx = res_q.final_idx;
    assign res_remapped  = res_q.remapped;
    assign res_spare_err = res_q.spare_err;
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lookup_valid,
    input logic [ADDR_W-1:0]        lookup_addr,
    input logic [NUM_CS*ADDR_W-1:0] cs_base_flat,
    input logic [NUM_CS*ADDR_W-1:0] cs_mask_flat,
    input logic [NUM_CS-1:0]        cs_enable,
    input logic [3:0]               retired_cs,
    input logic [3:0]               spare_cs,
    input logic                     res_valid,
    input logic                     res_hit,
    input logic [3:0]               res_match_idx,
    input logic [3:0]               res_final_idx,
    input logic                     res_remapped,
    input logic                     res_spare_err
);
    // Copy of the last sampled lookup
    logic [ADDR_W-1:0]        addr_q;
    logic [NUM_CS*ADDR_W-1:0] base_q;
    logic [NUM_CS*ADDR_W-1:0] mask_q;
    logic [NUM_CS-1:0]        en_q;
    logic [3:0]               retired_q;
    logic [3:0]               spare_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            base_q    <= '0;
            mask_q    <= '0;
            en_q      <= '0;
            retired_q <= '0;
            spare_q   <= '0;
        end else if (lookup_valid) begin
            addr_q    <= lookup_addr;
            base_q    <= cs_base_flat;
            mask_q    <= cs_mask_flat;
            en_q      <= cs_enable;
            retired_q <= retired_cs;
            spare_q   <= spare_cs;
        end
    end

    logic [NUM_CS-1:0] ok_vec;
    logic [NUM_CS-1:0] sel_oh;
    logic [NUM_CS-1:0] below;

    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            ok_vec[i] = en_q[i] &&
                (((addr_q ^ base_q[i*ADDR_W +: ADDR_W]) & ~mask_q[i*ADDR_W +: ADDR_W]) == '0);
            sel_oh[i] = (res_match_idx == 4'(i));
            below[i]  = (4'(i) < res_match_idx);
        end
    end

    assert_enable_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> |(en_q & sel_oh));

    assert_masked_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> |(ok_vec & sel_oh));

    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> ((ok_vec & below) == '0));

    assert_miss_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (ok_vec == '0 && !res_remapped && !res_spare_err));

    assert_redirect_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_remapped) |->
            (res_final_idx == spare_q && res_match_idx == retired_q && res_hit));

    assert_no_redirect_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_remapped) |-> (res_final_idx == res_match_idx));

    assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_remapped, res_spare_err}));

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> res_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> (!res_valid && $stable(res_final_idx) && $stable(res_hit)));
endmodule

bind cs_matcher csm_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) i_csm_checker (.*);

// File: tb/test_cs_matcher.sv
module test_cs_matcher;
    localparam int NCS = 8;
    localparam int AW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lookup_valid = 1'b0;
    logic [AW-1:0]     lookup_addr = '0;
    logic [NCS*AW-1:0] base_flat;
    logic [NCS*AW-1:0] mask_flat;
    logic [NCS-1:0]    cfg_en = '0;
    logic [3:0]        retired = 4'hF;
    logic [3:0]        spare = 4'hF;
    logic              res_valid, res_hit, res_remapped, res_spare_err;
    logic [3:0]        res_match_idx, res_final_idx;

    logic [AW-1:0] cfg_base [NCS];
    logic [AW-1:0] cfg_mask [NCS];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            base_flat[i*AW +: AW] = cfg_base[i];
            mask_flat[i*AW +: AW] = cfg_mask[i];
        end
    end

    cs_matcher #(.NUM_CS(NCS), .ADDR_W(AW)) i_cs_matcher (
        .clk           (clk),
        .rst_n         (rst_n),
        .lookup_valid  (lookup_valid),
        .lookup_addr   (lookup_addr),
        .cs_base_flat  (base_flat),
        .cs_mask_flat  (mask_flat),
        .cs_enable     (cfg_en),
        .retired_cs    (retired),
        .spare_cs      (spare),
        .res_valid     (res_valid),
        .res_hit       (res_hit),
        .res_match_idx (res_match_idx),
        .res_final_idx (res_final_idx),
        .res_remapped  (res_remapped),
        .res_spare_err (res_spare_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements
    task automatic lookup(input logic [AW-1:0] a, input string req);
        int e_hit, e_match, e_final, e_remap, e_err;
        e_hit = 0; e_match = 0;
        for (int i = 0; i < NCS; i++) begin
            if (e_hit == 0 && cfg_en[i] && (((a ^ cfg_base[i]) & ~cfg_mask[i]) == '0)) begin
                e_hit = 1; e_match = i;
            end
        end
        e_final = e_match; e_remap = 0; e_err = 0;
        if (e_hit == 1 && !(retired == 4'hF && spare == 4'hF) && e_match == int'(retired)) begin
            if (int'(spare) < NCS) begin e_final = int'(spare); e_remap = 1; end
            else e_err = 1;
        end
        @(negedge clk);
        lookup_addr  = a;
        lookup_valid = 1'b1;
        @(negedge clk);
        check(req, "valid", int'(res_valid), 1);
        check(req, "hit", int'(res_hit), e_hit);
        check(req, "match", int'(res_match_idx), e_match);
        check(req, "final", int'(res_final_idx), e_final);
        check(req, "remap", int'(res_remapped), e_remap);
        check(req, "err", int'(res_spare_err), e_err);
        lookup_valid = 1'b0;
    endtask

    task automatic default_cfg();
        for (int i = 0; i < NCS; i++) begin
            cfg_base[i] = AW'(i) << 28;
            cfg_mask[i] = 32'h0FFF_FFFF;
        end
        cfg_en  = '0;
        retired = 4'hF;
        spare   = 4'hF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] h_final;
        logic       h_hit;
        void'($urandom(32'd20240611));
        default_cfg();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "valid", int'(res_valid), 0);
        check("R9", "hit", int'(res_hit), 0);
        check("R9", "final", int'(res_final_idx), 0);
        check("R9", "remap_err", int'({res_remapped, res_spare_err}), 0);
        rst_n = 1'b1;

        // R1 and R4: matching base but all slots disabled
        lookup(32'h3000_0040, "R1");
        // R2: mask don't-care bits
        cfg_en = 8'hFF;
        cfg_mask[1] = 32'h00FF_FFFF;
        lookup(32'h10AB_CDEF, "R2");
        lookup(32'h11AB_CDEF, "R2");
        lookup(32'h11AB_CDEF, "R4");
        // R3: overlap between slots 2 and 5
        default_cfg();
        cfg_en = 8'hFF;
        cfg_base[5] = 32'h2000_0000;
        lookup(32'h2123_4567, "R3");
        cfg_en[2] = 1'b0;
        lookup(32'h2123_4567, "R1");
        // R5: redirect to a spare that is itself disabled and mismatched
        default_cfg();
        cfg_en = 8'h3F;
        retired = 4'd2; spare = 4'd6;
        lookup(32'h2000_1000, "R5");
        // R6: matched slot is not the retired one
        lookup(32'h4000_1000, "R6");
        retired = 4'hF; spare = 4'hF;
        lookup(32'h2000_1000, "R6");
        // R7: spare number absent
        retired = 4'd2; spare = 4'hF;
        lookup(32'h2000_1000, "R7");
        spare = 4'd9;
        lookup(32'h2000_1000, "R7");
        // R8: idle cycle holds result
        h_final = res_final_idx;
        h_hit   = res_hit;
        lookup_addr = 32'h7000_0000;
        retired = 4'd0; spare = 4'd1;
        @(negedge clk);
        check("R8", "valid", int'(res_valid), 0);
        check("R8", "final_hold", int'(res_final_idx), int'(h_final));
        check("R8", "hit_hold", int'(res_hit), int'(h_hit));

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            int pick;
            for (int i = 0; i < NCS; i++) begin
                cfg_base[i] = $urandom & 32'hFFFF_0000;
                cfg_mask[i] = ($urandom & 32'h0F0F_0000) | 32'h0000_FFFF;
            end
            cfg_en = 8'($urandom);
            pick = int'($urandom % NCS);
            if (($urandom % 4) == 0) cfg_base[(pick + 3) % NCS] = cfg_base[pick];
            a = cfg_base[pick] | ($urandom & cfg_mask[pick]);
            if (($urandom % 8) == 0) a = $urandom;
            retired = (($urandom % 4) == 0) ? 4'hF : 4'($urandom % NCS);
            spare   = 4'($urandom);
            lookup(a, (n % 2 == 0) ? "R5" : "R3");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule